// File: doc/BRIEF.md
# Privileged Trap Dispatch Controller

This block decides where fetch goes next when the pipeline takes a fault, interrupt or trap, and when it executes the privileged return instruction. For a taken event it adds a fixed per-cause vector offset to a programmable privileged base. It produces a redirect target and the following sequential address. It also produces a write of the restart address into the exception-address register and a request to switch into the shadow register bank. Privileged mode is carried in bit 0 of the program counter. The block itself holds no mode flag.

For a return it reads the saved exception address. It redirects there if the machine is in privileged mode, and asks to leave the shadow bank when bit 0 of that address is clear. Outside privileged mode it raises an illegal-instruction strobe instead. The register storage and the shadow bank live outside this block. All outputs are registered and appear one clock after the request is sampled.

Top module: `trap_dispatch_ctl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the outputs show a reset dispatch. `redirect_vld`=1, `new_pc`=`pal_base`+0x0001, `next_pc`=`new_pc`+4 and `shadow_enter`=1. `exc_wr_en`, `shadow_exit` and `illegal_op` are 0.
- R2: Cause codes on `fault_code` map to vector offsets as follows. 1 reset 0x0001, 2 machine check 0x0401, 3 arithmetic 0x0501, 4 interrupt 0x0101, 5 native data-TLB miss 0x0201, 6 privileged data-TLB miss 0x0281, 7 alignment 0x0301, 8 data-TLB fault 0x0381, 9 data access violation 0x0381, 10 instruction-TLB miss 0x0181, 11 instruction-TLB fault 0x0181, 12 instruction access violation 0x0081, 13 unimplemented opcode 0x0481, 14 FP disabled 0x0581, 15 privileged call 0x2001, 16 integer overflow 0x0501.
- R3: One cycle after `fault_vld` is sampled with a code from 1 to 16, `redirect_vld`=1, `new_pc`=`pal_base`+offset and `next_pc`=`new_pc`+4.
- R4: A taken fault writes `exc_wr_en`=1 with the current PC. The exception is an interrupt (code 4) taken while `cur_pc[0]`=1, which leaves `exc_wr_en`=0.
- R5: For arithmetic (code 3) and privileged call (code 15), the saved address is `cur_pc`+4.
- R6: A taken fault raises `shadow_enter` exactly when `cur_pc[0]`=0.
- R7: A return with `cur_pc[0]`=0 raises `illegal_op` for one cycle. It gives no redirect, no exception-address write and no shadow request.
- R8: A return with `cur_pc[0]`=1 redirects to `exc_addr_in`, with `next_pc`=`exc_addr_in`+4. It raises `shadow_exit` exactly when `exc_addr_in[0]`=0.
- R9: When a valid fault and a return are sampled together, the fault is dispatched and the return is dropped.
- R10: `fault_vld` with code 0 or a code above 16 is treated as no fault: no dispatch occurs, and a concurrent return proceeds.
- R11: With no request, all strobes (`redirect_vld`, `exc_wr_en`, `shadow_enter`, `shadow_exit`, `illegal_op`) are 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cur_pc | input | AW | PC of the instruction raising the event; bit 0 marks privileged mode |
| fault_vld | input | 1 | A fault, interrupt or trap is being taken |
| fault_code | input | 5 | Cause code (see R2) |
| ret_vld | input | 1 | Privileged return instruction is executing |
| pal_base | input | AW | Privileged base address |
| exc_addr_in | input | AW | Current contents of the exception-address register |
| redirect_vld | output | 1 | Fetch redirect valid |
| new_pc | output | AW | Redirect target |
| next_pc | output | AW | Address after the redirect target |
| exc_wr_en | output | 1 | Write strobe for the exception-address register |
| exc_wr_data | output | AW | Restart address to store |
| shadow_enter | output | 1 | Request to switch to the shadow bank |
| shadow_exit | output | 1 | Request to leave the shadow bank |
| illegal_op | output | 1 | Return attempted outside privileged mode |

## Verification
A wrong vector entry or adder shows up in the redirect target one cycle after the event. A faulty privileged-mode decode shows up in the same cycle as a missing or spurious `shadow_enter` or `exc_wr_en`, or as `illegal_op` on a legal return. The block has no state carried between requests apart from the output registers. Any error is therefore visible on the cycle right after the stimulus that caused it. Random stimulus mixes both settings of PC bit 0, every cause code plus out-of-range codes, and overlapping return and fault strobes. It is run against a reference model.

// File: rtl/trap_pkg.sv
// Package: shared cause encoding and the vector-offset function
// for the trap dispatch controller. Assumes offsets fit in 14 bits.
package trap_pkg;

    localparam int CODE_W = 5;
    localparam int OFF_W  = 14;

    typedef enum logic [CODE_W-1:0] {
        TC_NONE    = 5'd0,
        TC_RESET   = 5'd1,
        TC_MCHK    = 5'd2,
        TC_ARITH   = 5'd3,
        TC_INTR    = 5'd4,
        TC_NDTB    = 5'd5,
        TC_PDTB    = 5'd6,
        TC_ALIGN   = 5'd7,
        TC_DFAULT  = 5'd8,
        TC_DACV    = 5'd9,
        TC_IMISS   = 5'd10,
        TC_IFAULT  = 5'd11,
        TC_IACV    = 5'd12,
        TC_UNIMP   = 5'd13,
        TC_FPDIS   = 5'd14,
        TC_PRVCALL = 5'd15,
        TC_INTOVF  = 5'd16
    } trap_code_e;

    localparam logic [CODE_W-1:0] LAST_CODE = 5'd16;

    // Map a cause code to its vector offset; out-of-range codes give 0.
    function automatic logic [OFF_W-1:0] vec_offset(input logic [CODE_W-1:0] c);
        case (c)
            TC_RESET:            vec_offset = 14'h0001;
            TC_MCHK:             vec_offset = 14'h0401;
            TC_ARITH, TC_INTOVF: vec_offset = 14'h0501;
            TC_INTR:             vec_offset = 14'h0101;
            TC_NDTB:             vec_offset = 14'h0201;
            TC_PDTB:             vec_offset = 14'h0281;
            TC_ALIGN:            vec_offset = 14'h0301;
            TC_DFAULT, TC_DACV:  vec_offset = 14'h0381;
            TC_IMISS, TC_IFAULT: vec_offset = 14'h0181;
            TC_IACV:             vec_offset = 14'h0081;
            TC_UNIMP:            vec_offset = 14'h0481;
            TC_FPDIS:            vec_offset = 14'h0581;
            TC_PRVCALL:          vec_offset = 14'h2001;
            default:             vec_offset = '0;
        endcase
    endfunction

endpackage

// File: rtl/trap_vector_lut.sv
// Module: trap_vector_lut
// Turns a cause code into a redirect target (base + offset) and the next
// sequential address. Purely combinational. Assumes the base already
// holds the desired alignment; carries propagate across the full width.
module trap_vector_lut
    import trap_pkg::*;
#(
    parameter int AW = 64
) (
    input  logic [CODE_W-1:0] code,
    input  logic [AW-1:0]     base,
    output logic              code_ok,
    output logic [AW-1:0]     tgt_pc,
    output logic [AW-1:0]     tgt_npc
);
    localparam int INSN_BYTES = 4;

    logic [OFF_W-1:0] off;

    // Range check: codes 1..LAST_CODE are real causes.
    always_comb code_ok = (code != TC_NONE) && (code <= LAST_CODE);

    // Offset lookup and target arithmetic.
    always_comb begin
        off     = vec_offset(code);
        tgt_pc  = base + AW'(off);
        tgt_npc = base + AW'(off) + AW'(INSN_BYTES);
    end
endmodule

// File: rtl/trap_restart_sel.sv
// Module: trap_restart_sel
// Decides whether and what to store as the restart address for a taken
// fault, and whether the shadow bank must be entered. Combinational.
// Assumes privileged mode is cur_pc[0].
module trap_restart_sel
    import trap_pkg::*;
#(
    parameter int AW = 64
) (
    input  logic [CODE_W-1:0] code,
    input  logic [AW-1:0]     cur_pc,
    output logic              save_en,
    output logic [AW-1:0]     save_addr,
    output logic              enter_req
);
    localparam int INSN_BYTES = 4;

    logic in_priv;
    logic skip_insn;

    // Mode decode from the PC tag bit.
    always_comb in_priv = cur_pc[0];

    // Traps that resume after the faulting instruction.
    always_comb skip_insn = (code == TC_ARITH) || (code == TC_PRVCALL);

    // Save rule: interrupts taken in privileged mode keep the old address.
    always_comb begin
        save_en   = !((code == TC_INTR) && in_priv);
        save_addr = skip_insn ? (cur_pc + AW'(INSN_BYTES)) : cur_pc;
        enter_req = !in_priv;
    end
endmodule

// File: rtl/trap_return_unit.sv
// Module: trap_return_unit
// Resolves the privileged return: legal only in privileged mode, jumps to
// the stored exception address and leaves shadow mode if its bit 0 is 0.
module trap_return_unit #(
    parameter int AW = 64
) (
    input  logic          ret_req,
    input  logic          in_priv,
    input  logic [AW-1:0] exc_addr,
    output logic          ret_take,
    output logic          ret_bad,
    output logic [AW-1:0] ret_pc,
    output logic [AW-1:0] ret_npc,
    output logic          exit_req
);
    localparam int INSN_BYTES = 4;

    // Legality split and target computation.
    always_comb begin
        ret_take = ret_req && in_priv;
        ret_bad  = ret_req && !in_priv;
        ret_pc   = exc_addr;
        ret_npc  = exc_addr + AW'(INSN_BYTES);
        exit_req = ret_take && !exc_addr[0];
    end
endmodule

// File: rtl/trap_dispatch_ctl.sv
// Module: trap_dispatch_ctl (top)
// Arbitrates fault versus return (fault wins), and registers the redirect,
// restart-address write and shadow requests one cycle after sampling.
// Assumes pal_base is stable while rst_n is low; reset itself presents
// the reset vector dispatch on the outputs.
module trap_dispatch_ctl
    import trap_pkg::*;
#(
    parameter int AW = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     cur_pc,
    input  logic              fault_vld,
    input  logic [CODE_W-1:0] fault_code,
    input  logic              ret_vld,
    input  logic [AW-1:0]     pal_base,
    input  logic [AW-1:0]     exc_addr_in,
    output logic              redirect_vld,
    output logic [AW-1:0]     new_pc,
    output logic [AW-1:0]     next_pc,
    output logic              exc_wr_en,
    output logic [AW-1:0]     exc_wr_data,
    output logic              shadow_enter,
    output logic              shadow_exit,
    output logic              illegal_op
);
    localparam logic [AW-1:0] RST_OFF = AW'(vec_offset(TC_RESET));

    logic          code_ok;
    logic [AW-1:0] vec_pc, vec_npc;
    logic          save_en, enter_req;
    logic [AW-1:0] save_addr;
    logic          ret_take, ret_bad, exit_req;
    logic [AW-1:0] ret_pc, ret_npc;
    logic          take_fault, take_ret, bad_ret;

    trap_vector_lut #(.AW(AW)) u_vec (
        .code    (fault_code),
        .base    (pal_base),
        .code_ok (code_ok),
        .tgt_pc  (vec_pc),
        .tgt_npc (vec_npc)
    );

    trap_restart_sel #(.AW(AW)) u_rst_sel (
        .code      (fault_code),
        .cur_pc    (cur_pc),
        .save_en   (save_en),
        .save_addr (save_addr),
        .enter_req (enter_req)
    );

    trap_return_unit #(.AW(AW)) u_ret (
        .ret_req  (ret_vld),
        .in_priv  (cur_pc[0]),
        .exc_addr (exc_addr_in),
        .ret_take (ret_take),
        .ret_bad  (ret_bad),
        .ret_pc   (ret_pc),
        .ret_npc  (ret_npc),
        .exit_req (exit_req)
    );

    // Priority: a valid fault masks any concurrent return.
    always_comb begin
        take_fault = fault_vld && code_ok;
        take_ret   = !take_fault && ret_take;
        bad_ret    = !take_fault && ret_bad;
    end

    // Output register: reset vector during reset, else the selected action.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redirect_vld <= 1'b1;
            new_pc       <= pal_base + RST_OFF;
            next_pc      <= pal_base + RST_OFF + AW'(4);
            exc_wr_en    <= 1'b0;
            exc_wr_data  <= '0;
            shadow_enter <= 1'b1;
            shadow_exit  <= 1'b0;
            illegal_op   <= 1'b0;
        end else begin
            redirect_vld <= take_fault || take_ret;
            new_pc       <= take_fault ? vec_pc  : ret_pc;
            next_pc      <= take_fault ? vec_npc : ret_npc;
            exc_wr_en    <= take_fault && save_en;
            exc_wr_data  <= save_addr;
            shadow_enter <= take_fault && enter_req;
            shadow_exit  <= take_ret && exit_req;
            illegal_op   <= bad_ret;
        end
    end

    AST_NEXT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_vld |-> next_pc == new_pc + AW'(4)); // R3
    AST_SHADOW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(shadow_enter && shadow_exit)); // R8
    AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_op |-> !redirect_vld && !exc_wr_en && !shadow_enter); // R7
    AST_PRIV_INTR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_vld && fault_code == TC_INTR && cur_pc[0]) |=> !exc_wr_en); // R4
    AST_FAULT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_vld && fault_code != TC_NONE && fault_code <= LAST_CODE)
        |=> redirect_vld && !illegal_op && !shadow_exit); // R9
    AST_BAD_CODE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_vld && (fault_code == TC_NONE || fault_code > LAST_CODE) && !ret_vld)
        |=> !redirect_vld && !exc_wr_en && !shadow_enter); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!fault_vld && !ret_vld) |=> !redirect_vld && !exc_wr_en && !illegal_op); // R11
endmodule

// File: tb/test_trap_dispatch_ctl.sv
module test_trap_dispatch_ctl;
    localparam int AW = 64;

    logic          clk = 0;
    logic          rst_n = 0;
    logic [AW-1:0] cur_pc = '0, pal_base = '0, exc_addr_in = '0;
    logic          fault_vld = 0, ret_vld = 0;
    logic [4:0]    fault_code = '0;
    logic          redirect_vld, exc_wr_en, shadow_enter, shadow_exit, illegal_op;
    logic [AW-1:0] new_pc, next_pc, exc_wr_data;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    trap_dispatch_ctl #(.AW(AW)) i_trap_dispatch_ctl (
        .clk, .rst_n, .cur_pc, .fault_vld, .fault_code, .ret_vld, .pal_base,
        .exc_addr_in, .redirect_vld, .new_pc, .next_pc, .exc_wr_en,
        .exc_wr_data, .shadow_enter, .shadow_exit, .illegal_op
    );

    typedef struct {
        logic          rv, we, se, sx, il;
        logic [AW-1:0] np, nn, wd;
    } exp_t;

    function automatic logic [AW-1:0] offs(input logic [4:0] c);
        case (c)
            1: return 64'h0001;   2: return 64'h0401;   3: return 64'h0501;
            4: return 64'h0101;   5: return 64'h0201;   6: return 64'h0281;
            7: return 64'h0301;   8: return 64'h0381;   9: return 64'h0381;
            10: return 64'h0181;  11: return 64'h0181;  12: return 64'h0081;
            13: return 64'h0481;  14: return 64'h0581;  15: return 64'h2001;
            16: return 64'h0501;
            default: return 64'h0;
        endcase
    endfunction

    function automatic exp_t model(input logic fv, input logic [4:0] fc, input logic rv,
                                   input logic [AW-1:0] pc, base, ea);
        exp_t e;
        e = '{default: '0};
        if (fv && fc >= 1 && fc <= 16) begin
            e.rv = 1; e.np = base + offs(fc); e.nn = e.np + 4;
            e.we = !(fc == 4 && pc[0]);
            e.wd = pc + ((fc == 3 || fc == 15) ? 64'd4 : 64'd0);
            e.se = !pc[0];
        end else if (rv) begin
            if (pc[0]) begin
                e.rv = 1; e.np = ea; e.nn = ea + 4; e.sx = !ea[0];
            end else e.il = 1;
        end
        return e;
    endfunction

    task automatic chk(input string req, input string what, input logic [AW-1:0] act, exp_v);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp_v);
        end
    endtask

    // Drive one request at a negedge, then compare at the next negedge.
    task automatic step(input logic fv, input logic [4:0] fc, input logic rv,
                        input logic [AW-1:0] pc, base, ea, input string req);
        exp_t e;
        fault_vld = fv; fault_code = fc; ret_vld = rv;
        cur_pc = pc; pal_base = base; exc_addr_in = ea;
        e = model(fv, fc, rv, pc, base, ea);
        @(negedge clk);
        chk(req, "redirect_vld", 64'(redirect_vld), 64'(e.rv));
        if (e.rv) begin
            chk(req, "new_pc", new_pc, e.np);
            chk(req, "next_pc", next_pc, e.nn);
        end
        chk(req, "exc_wr_en", 64'(exc_wr_en), 64'(e.we));
        if (e.we) chk(req, "exc_wr_data", exc_wr_data, e.wd);
        chk(req, "shadow_enter", 64'(shadow_enter), 64'(e.se));
        chk(req, "shadow_exit", 64'(shadow_exit), 64'(e.sx));
        chk(req, "illegal_op", 64'(illegal_op), 64'(e.il));
    endtask

    function automatic logic [AW-1:0] r64();
        return {$urandom(), $urandom()};
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] base;
        void'($urandom(32'h1f3a));
        base = 64'h0000_0000_0040_0000;
        pal_base = base;
        repeat (3) @(negedge clk);
        // R1: reset dispatch visible while reset is held
        chk("R1", "redirect_vld", 64'(redirect_vld), 64'd1);
        chk("R1", "new_pc", new_pc, base + 64'h1);
        chk("R1", "next_pc", next_pc, base + 64'h5);
        chk("R1", "shadow_enter", 64'(shadow_enter), 64'd1);
        chk("R1", "exc_wr_en", 64'(exc_wr_en), 64'd0);
        chk("R1", "illegal_op", 64'(illegal_op), 64'd0);
        rst_n = 1;
        // R11: idle
        step(0, 0, 0, 64'h1000, base, 64'h0, "R11");
        // R2 / R3: every code from user mode, sweeps the vector table
        for (int c = 1; c <= 16; c++)
            step(1, 5'(c), 0, 64'h2_0000 + 64'(c * 16), base, 64'h0, "R2");
        // R4: interrupt in privileged mode keeps exception address
        step(1, 4, 0, 64'h3001, base, 64'h0, "R4");
        step(1, 4, 0, 64'h3000, base, 64'h0, "R4");
        // R5: arithmetic and privileged call skip instruction
        step(1, 3, 0, 64'h4000, base, 64'h0, "R5");
        step(1, 15, 0, 64'h4001, base, 64'h0, "R5");
        // R6: privileged fault does not request shadow entry
        step(1, 7, 0, 64'h5001, base, 64'h0, "R6");
        // R7: return from user mode is illegal
        step(0, 0, 1, 64'h6000, base, 64'h7000, "R7");
        // R8: legal returns, both exit settings
        step(0, 0, 1, 64'h6001, base, 64'h7000, "R8");
        step(0, 0, 1, 64'h6001, base, 64'h7001, "R8");
        // R9: fault beats return
        step(1, 13, 1, 64'h6001, base, 64'h7000, "R9");
        step(1, 2, 1, 64'h6000, base, 64'h7000, "R9");
        // R10: out-of-range codes ignored, concurrent return proceeds
        step(1, 0, 0, 64'h8000, base, 64'h0, "R10");
        step(1, 17, 0, 64'h8000, base, 64'h0, "R10");
        step(1, 31, 1, 64'h8001, base, 64'h9000, "R10");
        // Random mix against the model
        for (int i = 0; i < 3000; i++) begin
            logic fv, rv;
            logic [4:0] fc;
            fv = ($urandom() % 3) != 0;
            rv = ($urandom() % 3) == 0;
            fc = 5'($urandom() % 20);
            step(fv, fc, rv, r64(), r64() & ~64'h3fff, r64(), "R3");
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule